// File: doc/BRIEF.md
# Boot-Mode Latch and Shared Interrupt Pin Controller

This block owns four active-low chip pins that play three roles over their life. While the chip reset is held low, the synchronized pin levels feed a mode register that follows them. The register freezes on the first clock after reset is released, handing the chip its boot operating mode, one of sixteen. From then on each pin is configured on its own as a maskable interrupt request, a general-purpose input, a general-purpose output, or a disconnected pin. An interrupt request is either level-sensitive or triggered by a falling edge.

Every pin passes through a two-flop synchronizer before any logic uses it. A small controller with three named states orders the start-up. `ST_RESET` is the asynchronous reset state, in which the mode register tracks the pins. Transition T_RELEASE is the first clock with reset high: the mode is captured and the controller moves to `ST_SETTLE`. Transition T_ARM takes it on the next clock to `ST_RUN`, where interrupts and output enables become live. Transition T_RESET is the asynchronous return to `ST_RESET` whenever reset goes low. Software writes the configuration through a simple write strobe with a pin select. It clears pending edge requests with a write-one-to-clear vector.

Top module: `mode_irq_ctrl`

## Requirements
- R1: On the first rising clock edge after `rst_n` goes high, `mode_o` takes the synchronized pin levels; bit i is the level of `pin_i[i]` (1 = high), not inverted.
- R2: While `rst_n` is low, `mode_o` follows the pins with three clock edges of delay: two synchronizer stages plus the mode register.
- R3: Once captured, `mode_o` holds its value whatever the pins do, until the next reset release.
- R4: While reset is low, and during the one settling cycle after it, `irq_o`, `pad_oe_o` and `pad_do_o` are all zero. After reset every pin is an interrupt pin (function code 2'b00), level-triggered (trigger code 0), masked (enable 0).
- R5: An enabled level-triggered interrupt pin (function 2'b00, trigger 0) drives `irq_o` high while its synchronized level is low. A pin falling between two clock edges shows on `irq_o` after the second rising edge and not after the first. `irq_o` drops again once the pin has been high for two edges.
- R6: A pin with enable 0 never raises `irq_o`, even when low. Setting enable while the pin is still low raises the request at once.
- R7: An enabled falling-edge interrupt pin (trigger 1) sets a pending request on a high-to-low transition. `irq_o` stays high after the pin returns high, until a one in the matching bit of `pend_clr` clears it.
- R8: A falling-edge pin held low after its request is cleared raises no new request. Only a fresh high-to-low transition does.
- R9: A general-purpose input pin (function 2'b01) reports its synchronized level on `gpio_rd_o`, keeps `pad_oe_o` at 0 and never raises `irq_o`.
- R10: A general-purpose output pin (function 2'b10) drives `pad_oe_o` high and `pad_do_o` with the bit last written through `gpo_we`/`gpo_data`. It never raises `irq_o`.
- R11: A disconnected pin (function 2'b11) reads 0 on `gpio_rd_o` at any pin level, keeps `pad_oe_o` at 0 and never raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| pin_i | input | 4 | Raw pad levels, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Pin index for the configuration write |
| cfg_func | input | 2 | Function: 00 interrupt, 01 input, 10 output, 11 disconnected |
| cfg_trig | input | 1 | Trigger: 0 low level, 1 falling edge |
| cfg_en | input | 1 | Interrupt enable (mask when 0) |
| gpo_we | input | 1 | Output-data write strobe |
| gpo_data | input | 4 | Output data for all pins |
| pend_clr | input | 4 | Write-one-to-clear for pending edge requests |
| mode_o | output | 4 | Latched boot operating mode |
| irq_o | output | 4 | Per-pin interrupt request |
| gpio_rd_o | output | 4 | Per-pin read data |
| pad_oe_o | output | 4 | Per-pin output enable |
| pad_do_o | output | 4 | Per-pin output data |

## Verification
Reset is applied twice with different pin patterns, and the pins change both during reset and after release. A latch that kept the first pattern, froze too early or kept tracking after release shows a wrong `mode_o`. The bench samples a level request one and two edges after a pin falls, which catches a missing or extra synchronizer stage. For falling-edge pins it releases the pin before clearing and holds it low after clearing. A pending bit that follows the level, or is set again by a held-low pin, then shows up. The general-purpose and disconnected pins are driven low to confirm they never request. The disconnected pin is read at both levels.

// File: rtl/mic_pkg.sv
package mic_pkg;

    typedef enum logic [1:0] {
        FN_IRQ   = 2'b00,
        FN_GPIN  = 2'b01,
        FN_GPOUT = 2'b10,
        FN_OFF   = 2'b11
    } pin_func_e;

    typedef enum logic [1:0] {
        ST_RESET  = 2'b00,
        ST_SETTLE = 2'b01,
        ST_RUN    = 2'b10
    } ctrl_state_e;

    localparam logic TRIG_LEVEL = 1'b0;
    localparam logic TRIG_FALL  = 1'b1;

endpackage

// File: rtl/mic_sync.sv
// Multi-stage synchronizer without reset, so that it keeps following the
// pins while the chip is held in reset; also keeps one delayed copy for
// edge detection.
module mic_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] prev
);

    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) chain[s] <= din;
        end else begin : g_next
            always_ff @(posedge clk) chain[s] <= chain[s-1];
        end
    end

    always_ff @(posedge clk) prev_q <= chain[STAGES-1];

    assign dout = chain[STAGES-1];
    assign prev = prev_q;

endmodule

// File: rtl/mic_cfg.sv
// Per-pin configuration registers and shared output-data register.
module mic_cfg
    import mic_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int SEL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  pin_func_e               cfg_func,
    input  logic                    cfg_trig,
    input  logic                    cfg_en,
    input  logic                    gpo_we,
    input  logic [NPINS-1:0]        gpo_data,
    output pin_func_e [NPINS-1:0]   func_o,
    output logic [NPINS-1:0]        trig_o,
    output logic [NPINS-1:0]        en_o,
    output logic [NPINS-1:0]        gpo_o
);

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic hit;
        assign hit = cfg_we && (cfg_sel == SEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                func_o[g] <= FN_IRQ;
                trig_o[g] <= TRIG_LEVEL;
                en_o[g]   <= 1'b0;
            end else if (hit) begin
                func_o[g] <= cfg_func;
                trig_o[g] <= cfg_trig;
                en_o[g]   <= cfg_en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      gpo_o <= '0;
        else if (gpo_we) gpo_o <= gpo_data;
    end

endmodule

// File: rtl/mic_irq.sv
// Interrupt request generation: level follow or sticky falling-edge pending.
module mic_irq
    import mic_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [NPINS-1:0]        pin_s,
    input  logic [NPINS-1:0]        pin_prev,
    input  pin_func_e [NPINS-1:0]   func,
    input  logic [NPINS-1:0]        trig,
    input  logic [NPINS-1:0]        en,
    input  logic [NPINS-1:0]        pend_clr,
    output logic [NPINS-1:0]        irq_o
);

    logic [NPINS-1:0] pend_q;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic armed;
        logic fall;
        logic pend_d;

        assign armed = run && (func[g] == FN_IRQ) && en[g];
        assign fall  = pin_prev[g] && !pin_s[g];

        always_comb begin
            if (!armed || (trig[g] != TRIG_FALL)) pend_d = 1'b0;
            else                                  pend_d = (pend_q[g] && !pend_clr[g]) || fall;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q[g] <= 1'b0;
            else        pend_q[g] <= pend_d;
        end

        assign irq_o[g] = armed && ((trig[g] == TRIG_FALL) ? pend_q[g] : !pin_s[g]);
    end

endmodule

// File: rtl/mode_irq_ctrl.sv
// Top: start-up controller, boot-mode latch, pin function muxing.
module mode_irq_ctrl
    import mic_pkg::*;
#(
    parameter int NPINS       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [1:0]       cfg_func,
    input  logic             cfg_trig,
    input  logic             cfg_en,
    input  logic             gpo_we,
    input  logic [NPINS-1:0] gpo_data,
    input  logic [NPINS-1:0] pend_clr,
    output logic [NPINS-1:0] mode_o,
    output logic [NPINS-1:0] irq_o,
    output logic [NPINS-1:0] gpio_rd_o,
    output logic [NPINS-1:0] pad_oe_o,
    output logic [NPINS-1:0] pad_do_o
);

    ctrl_state_e            state_q;
    ctrl_state_e            state_d;
    logic                   track_mode;
    logic                   run;
    logic [NPINS-1:0]       pin_s;
    logic [NPINS-1:0]       pin_prev;
    logic [NPINS-1:0]       mode_q;
    pin_func_e [NPINS-1:0]  func_q;
    logic [NPINS-1:0]       trig_q;
    logic [NPINS-1:0]       en_q;
    logic [NPINS-1:0]       gpo_q;

    // State register (T_RESET is the asynchronous entry)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = ST_SETTLE;  // T_RELEASE
            ST_SETTLE: state_d = ST_RUN;     // T_ARM
            ST_RUN:    state_d = ST_RUN;
            default:   state_d = ST_RESET;
        endcase
    end

    // State outputs
    always_comb begin
        track_mode = 1'b0;
        run        = 1'b0;
        unique case (state_q)
            ST_RESET:  track_mode = 1'b1;
            ST_SETTLE: ;
            ST_RUN:    run = 1'b1;
            default:   ;
        endcase
    end

    mic_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (pin_i),
        .dout (pin_s),
        .prev (pin_prev)
    );

    // Boot-mode latch: follows pins in reset, last load at T_RELEASE
    always_ff @(posedge clk) begin
        if (track_mode) mode_q <= pin_s;
    end
    assign mode_o = mode_q;

    mic_cfg #(.NPINS(NPINS), .SEL_W(SEL_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_func (pin_func_e'(cfg_func)),
        .cfg_trig (cfg_trig),
        .cfg_en   (cfg_en),
        .gpo_we   (gpo_we),
        .gpo_data (gpo_data),
        .func_o   (func_q),
        .trig_o   (trig_q),
        .en_o     (en_q),
        .gpo_o    (gpo_q)
    );

    mic_irq #(.NPINS(NPINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .pin_s    (pin_s),
        .pin_prev (pin_prev),
        .func     (func_q),
        .trig     (trig_q),
        .en       (en_q),
        .pend_clr (pend_clr),
        .irq_o    (irq_o)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pad
        assign gpio_rd_o[g] = (func_q[g] == FN_OFF) ? 1'b0 : pin_s[g];
        assign pad_oe_o[g]  = run && (func_q[g] == FN_GPOUT);
        assign pad_do_o[g]  = pad_oe_o[g] && gpo_q[g];
    end

endmodule

// File: rtl/mode_irq_ctrl_chk.sv
module mode_irq_ctrl_chk
    import mic_pkg::*;
#(
    parameter int NPINS       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPINS-1:0]      pin_i,
    input  logic [NPINS-1:0]      pend_clr,
    input  logic [NPINS-1:0]      mode_o,
    input  logic [NPINS-1:0]      irq_o,
    input  logic [NPINS-1:0]      gpio_rd_o,
    input  logic [NPINS-1:0]      pad_oe_o,
    input  ctrl_state_e           state_q,
    input  pin_func_e [NPINS-1:0] func_q,
    input  logic [NPINS-1:0]      trig_q,
    input  logic [NPINS-1:0]      en_q
);

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RESET && $past(state_q) != ST_RESET) |-> $stable(mode_o)); // R3

    AST_QUIET_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> (irq_o == '0 && pad_oe_o == '0)); // R4

    AST_OE_IRQ_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe_o & irq_o) == '0); // R10

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[g] |-> !irq_o[g]); // R6

        AST_OFF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (func_q[g] == FN_OFF) |-> (!gpio_rd_o[g] && !pad_oe_o[g] && !irq_o[g])); // R11

        AST_GPIN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            (func_q[g] == FN_GPIN) |-> (!irq_o[g] && !pad_oe_o[g])); // R9

        AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_RUN && func_q[g] == FN_IRQ && trig_q[g] == TRIG_FALL && en_q[g]
             && $stable(func_q[g]) && $stable(trig_q[g]) && $stable(en_q[g])
             && $past(irq_o[g]) && !$past(pend_clr[g])) |-> irq_o[g]); // R7

        if (SYNC_STAGES == 2) begin : g_lvl
            AST_LEVEL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_RUN && func_q[g] == FN_IRQ && trig_q[g] == TRIG_LEVEL && irq_o[g])
                |-> ($past(pin_i[g], 2) == 1'b0)); // R5
        end
    end

endmodule

bind mode_irq_ctrl mode_irq_ctrl_chk #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .pend_clr  (pend_clr),
    .mode_o    (mode_o),
    .irq_o     (irq_o),
    .gpio_rd_o (gpio_rd_o),
    .pad_oe_o  (pad_oe_o),
    .state_q   (state_q),
    .func_q    (func_q),
    .trig_q    (trig_q),
    .en_q      (en_q)
);

// File: tb/mode_irq_ctrl_test.sv
module mode_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_i = 4'b1111;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [1:0] cfg_func = 2'b00;
    logic       cfg_trig = 1'b0;
    logic       cfg_en = 1'b0;
    logic       gpo_we = 1'b0;
    logic [3:0] gpo_data = 4'b0000;
    logic [3:0] pend_clr = 4'b0000;
    logic [3:0] mode_o, irq_o, gpio_rd_o, pad_oe_o, pad_do_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_func(cfg_func),
        .cfg_trig(cfg_trig), .cfg_en(cfg_en),
        .gpo_we(gpo_we), .gpo_data(gpo_data), .pend_clr(pend_clr),
        .mode_o(mode_o), .irq_o(irq_o), .gpio_rd_o(gpio_rd_o),
        .pad_oe_o(pad_oe_o), .pad_do_o(pad_do_o)
    );

    task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(int pin, logic [1:0] f, logic t, logic e);
        cfg_sel  = pin[1:0];
        cfg_func = f;
        cfg_trig = t;
        cfg_en   = e;
        cfg_we   = 1'b1;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic write_gpo(logic [3:0] d);
        gpo_data = d;
        gpo_we   = 1'b1;
        @(negedge clk);
        gpo_we   = 1'b0;
    endtask

    // R1 R2 R4: mode tracking in reset, capture at release, quiet outputs
    task automatic t_reset_capture(logic [3:0] first, logic [3:0] last);
        @(negedge clk);
        rst_n = 1'b0;
        pin_i = first;
        cycles(5);
        check("R2", "mode tracks pins in reset", mode_o, first);
        check("R4", "irq in reset", irq_o, 4'b0000);
        check("R4", "oe in reset", pad_oe_o, 4'b0000);
        check("R4", "do in reset", pad_do_o, 4'b0000);
        pin_i = last;
        cycles(2);
        check("R2", "mode not yet updated after two edges", mode_o, first);
        cycles(1);
        check("R2", "mode updated after three edges", mode_o, last);
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
        check("R1", "mode captured at release", mode_o, last);
        check("R4", "irq in settle cycle", irq_o, 4'b0000);
        pin_i = 4'b1111;
        cycles(1);
    endtask

    // R3: pins move after capture, mode holds
    task automatic t_mode_hold(logic [3:0] captured);
        pin_i = ~captured;
        cycles(5);
        check("R3", "mode holds after release", mode_o, captured);
        pin_i = 4'b1111;
        cycles(3);
        check("R3", "mode still holds", mode_o, captured);
    endtask

    // R4 R5 R6: level trigger, synchronizer delay, mask
    task automatic t_level();
        pin_i = 4'b1110;
        cycles(4);
        check("R4", "default config is masked", irq_o, 4'b0000);
        pin_i = 4'b1111;
        cycles(3);
        set_cfg(0, 2'b00, 1'b0, 1'b1);
        check("R5", "idle high pin no request", irq_o, 4'b0000);
        pin_i = 4'b1110;
        cycles(1);
        check("R5", "no request after one edge", irq_o, 4'b0000);
        cycles(1);
        check("R5", "request after two edges", irq_o, 4'b0001);
        pin_i = 4'b1111;
        cycles(2);
        check("R5", "request drops with pin high", irq_o, 4'b0000);
        set_cfg(1, 2'b00, 1'b0, 1'b0);
        pin_i = 4'b1101;
        cycles(4);
        check("R6", "masked pin silent", irq_o, 4'b0000);
        set_cfg(1, 2'b00, 1'b0, 1'b1);
        check("R6", "unmask while low raises request", irq_o, 4'b0010);
        pin_i = 4'b1111;
        cycles(3);
        set_cfg(1, 2'b00, 1'b0, 1'b0);
    endtask

    // R7 R8: falling-edge pending
    task automatic t_edge();
        set_cfg(2, 2'b00, 1'b1, 1'b1);
        check("R7", "edge pin idle", irq_o, 4'b0000);
        pin_i = 4'b1011;
        cycles(4);
        check("R7", "falling edge sets request", irq_o, 4'b0100);
        pin_i = 4'b1111;
        cycles(4);
        check("R7", "request sticky after pin high", irq_o, 4'b0100);
        pend_clr = 4'b0100;
        cycles(1);
        pend_clr = 4'b0000;
        check("R7", "clear removes request", irq_o, 4'b0000);
        pin_i = 4'b1011;
        cycles(4);
        check("R8", "second falling edge", irq_o, 4'b0100);
        pend_clr = 4'b0100;
        cycles(1);
        pend_clr = 4'b0000;
        cycles(4);
        check("R8", "held low gives no new request", irq_o, 4'b0000);
        pin_i = 4'b1111;
        cycles(3);
        set_cfg(2, 2'b00, 1'b0, 1'b0);
    endtask

    // R9: general-purpose input
    task automatic t_gpio_in();
        set_cfg(3, 2'b01, 1'b0, 1'b1);
        pin_i = 4'b0111;
        cycles(3);
        check("R9", "input reads low", gpio_rd_o, 4'b0111);
        check("R9", "input no request", irq_o, 4'b0000);
        check("R9", "input oe off", pad_oe_o, 4'b0000);
        pin_i = 4'b1111;
        cycles(3);
        check("R9", "input reads high", gpio_rd_o, 4'b1111);
    endtask

    // R10: general-purpose output
    task automatic t_gpio_out();
        set_cfg(0, 2'b10, 1'b0, 1'b1);
        write_gpo(4'b1111);
        check("R10", "output enable", pad_oe_o, 4'b0001);
        check("R10", "output data high", pad_do_o, 4'b0001);
        pin_i = 4'b1110;
        cycles(4);
        check("R10", "output pin no request", irq_o, 4'b0000);
        write_gpo(4'b0000);
        check("R10", "output data low", pad_do_o, 4'b0000);
        check("R10", "output still enabled", pad_oe_o, 4'b0001);
        pin_i = 4'b1111;
        cycles(3);
    endtask

    // R11: disconnected
    task automatic t_off();
        set_cfg(1, 2'b11, 1'b0, 1'b1);
        pin_i = 4'b1101;
        cycles(4);
        check("R11", "off pin reads 0 when low", gpio_rd_o & 4'b0010, 4'b0000);
        check("R11", "off pin no request", irq_o & 4'b0010, 4'b0000);
        check("R11", "off pin oe off", pad_oe_o & 4'b0010, 4'b0000);
        pin_i = 4'b1111;
        cycles(4);
        check("R11", "off pin reads 0 when high", gpio_rd_o & 4'b0010, 4'b0000);
    endtask

    initial begin
        cycles(2);
        t_reset_capture(4'b1010, 4'b0110);
        t_mode_hold(4'b0110);
        t_level();
        t_edge();
        t_gpio_in();
        t_gpio_out();
        t_off();
        t_reset_capture(4'b0011, 4'b1001);
        t_mode_hold(4'b1001);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule